// File: doc/BRIEF.md
# Saturating Up/Down Wiper Position Counter

This block is the digital core of a 128-tap push-button potentiometer. It holds a 7-bit wiper code. The code steps by one position each time the count strobe falls while the chip is selected. Three asynchronous control lines drive it: a count strobe, an active-low select and an up/down direction line. Each line is brought into the system clock domain through its own two-flop synchroniser. A small state machine watches the synchronised strobe and produces a one-cycle step request on each high-to-low transition.

The counter loads midscale (0x40) at reset. It counts up toward terminal A when direction is high and down toward terminal B when direction is low. It stops at 0x7F and at 0x00 rather than wrapping. Next to the code, the block registers a one-hot 128-bit tap select whose set bit index equals the code. The analog divider fraction is therefore code/128 of the terminal voltage, with no extra command needed.

The strobe state machine has two states:
- `STB_DISARMED` is entered at reset and while the synchronised strobe is low.
- `STB_ARMED` is entered once the synchronised strobe has been seen high.

The `arm` transition (DISARMED to ARMED) happens when the synchronised strobe is high. The `fire` transition (ARMED to DISARMED) happens when the synchronised strobe is low, and it raises the step request for that one cycle. All other cases hold the current state.

Top module: `wiper_ctrl`

## Requirements
- R1: Synchronous active-high reset loads code 0x40 and sets only tap bit 64.
- R2: The code changes only on a strobe high-to-low transition. A rising strobe, or a strobe held at either level, leaves it unchanged.
- R3: With select low and direction high, each strobe fall adds one to the code.
- R4: With select low and direction low, each strobe fall subtracts one from the code.
- R5: With select high, strobe falls are ignored and the code holds.
- R6: At 0x7F, further upward strobe falls leave the code at 0x7F; it never wraps to 0x00.
- R7: At 0x00, further downward strobe falls leave the code at 0x00; it never wraps to 0x7F.
- R8: `tap_sel` always has exactly one bit set, at index equal to `wiper_code`, and changes in the same cycle as the code.
- R9: The code changes on the third rising clock edge at which the strobe input is sampled low. The direction and select values used are those sampled at the first of those edges, since all three lines have equal synchroniser depth.
- R10: A strobe held low for many cycles produces exactly one step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| strobe_in | input | 1 | Asynchronous count strobe; the count acts on the falling edge |
| sel_n_in | input | 1 | Asynchronous chip select, active low |
| dir_in | input | 1 | Asynchronous direction: 1 counts up, 0 counts down |
| wiper_code | output | 7 | Current wiper position, 0x00 to 0x7F |
| tap_sel | output | 128 | One-hot tap select, bit index equals `wiper_code` |

## Verification
The assertions assume the control lines are clean, already-debounced levels, so each physical strobe fall reaches the state machine as one low period. They also assume direction and select are stable at the sampled strobe fall, meaning they are driven no later than the strobe fall itself. The stimulus changes inputs only at the falling clock edge and holds each strobe level for at least three cycles. Direction and select are driven together with or before the strobe fall, except in one deliberate case: direction is flipped one cycle after the fall, to show that the value present at the fall is the one used.

// File: rtl/wiper_pkg.sv
package wiper_pkg;

    // Strobe edge-detector states
    typedef enum logic [0:0] {
        STB_DISARMED = 1'b0,  // strobe low, or not yet seen high since reset
        STB_ARMED    = 1'b1   // strobe seen high, a fall will fire
    } strobe_state_t;

endpackage

// File: rtl/wiper_sync.sv
module wiper_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= '0;
            end
        end else begin
            stage_q[0] <= async_in;
            for (int i = 1; i < STAGES; i++) begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/wiper_strobe_fsm.sv
module wiper_strobe_fsm
    import wiper_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic strobe_s,
    output logic fall_evt
);

    strobe_state_t state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= STB_DISARMED;
        end else begin
            state_q <= state_d;
        end
    end

    // next state: arm on high, fire on low
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            STB_DISARMED: if (strobe_s)  state_d = STB_ARMED;
            STB_ARMED:    if (!strobe_s) state_d = STB_DISARMED;
            default:      state_d = STB_DISARMED;
        endcase
    end

    // outputs: one-cycle event on the fire transition
    always_comb begin
        fall_evt = 1'b0;
        unique case (state_q)
            STB_DISARMED: fall_evt = 1'b0;
            STB_ARMED:    fall_evt = !strobe_s;
            default:      fall_evt = 1'b0;
        endcase
    end

endmodule

// File: rtl/wiper_counter.sv
module wiper_counter #(
    parameter int CODE_W = 7,
    localparam int TAPS  = 1 << CODE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step_en,
    input  logic              step_up,
    output logic [CODE_W-1:0] code_q,
    output logic [TAPS-1:0]   tap_q
);

    localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(TAPS / 2);
    localparam logic [CODE_W-1:0] MAX_CODE = '1;
    localparam logic [CODE_W-1:0] MIN_CODE = '0;

    logic [CODE_W-1:0] code_d;
    logic [TAPS-1:0]   tap_d;

    always_comb begin
        code_d = code_q;
        if (step_en) begin
            if (step_up && (code_q != MAX_CODE)) begin
                code_d = code_q + 1'b1;
            end else if (!step_up && (code_q != MIN_CODE)) begin
                code_d = code_q - 1'b1;
            end
        end
    end

    for (genvar i = 0; i < TAPS; i++) begin : g_tap
        assign tap_d[i] = (code_d == CODE_W'(i));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= MID_CODE;
            tap_q  <= TAPS'(1) << MID_CODE;
        end else begin
            code_q <= code_d;
            tap_q  <= tap_d;
        end
    end

endmodule

// File: rtl/wiper_ctrl.sv
module wiper_ctrl #(
    parameter int CODE_W      = 7,
    parameter int SYNC_STAGES = 2,
    localparam int TAPS       = 1 << CODE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe_in,
    input  logic              sel_n_in,
    input  logic              dir_in,
    output logic [CODE_W-1:0] wiper_code,
    output logic [TAPS-1:0]   tap_sel
);

    logic [2:0] raw_in;
    logic [2:0] sync_v;
    logic       strobe_s;
    logic       cs_n_s;
    logic       dir_s;
    logic       fall_evt;

    assign raw_in = {dir_in, sel_n_in, strobe_in};

    wiper_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (raw_in),
        .sync_out (sync_v)
    );

    assign strobe_s = sync_v[0];
    assign cs_n_s   = sync_v[1];
    assign dir_s    = sync_v[2];

    wiper_strobe_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .strobe_s (strobe_s),
        .fall_evt (fall_evt)
    );

    wiper_counter #(
        .CODE_W (CODE_W)
    ) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .step_en (fall_evt && !cs_n_s),
        .step_up (dir_s),
        .code_q  (wiper_code),
        .tap_q   (tap_sel)
    );

endmodule

// File: rtl/wiper_ctrl_checker.sv
module wiper_ctrl_checker #(
    parameter int CODE_W = 7,
    localparam int TAPS  = 1 << CODE_W
) (
    input logic              clk,
    input logic              rst,
    input logic [CODE_W-1:0] code,
    input logic [TAPS-1:0]   tap,
    input logic              fall_evt,
    input logic              cs_n_s,
    input logic              dir_s
);

    localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(TAPS / 2);
    localparam logic [CODE_W-1:0] MAX_CODE = '1;
    localparam logic [CODE_W-1:0] MIN_CODE = '0;

    logic rst_d = 1'b0;

    always @(posedge clk) begin
        if (rst_d) begin
            assert_reset_mid_R1: assert (code == MID_CODE);
        end
        rst_d <= rst;
    end

    assert_no_move_without_fall_R2: assert property (@(posedge clk) disable iff (rst)
        !fall_evt |=> $stable(code));

    assert_count_up_R3: assert property (@(posedge clk) disable iff (rst)
        (fall_evt && !cs_n_s && dir_s && code != MAX_CODE)
        |=> ({1'b0, code} == {1'b0, $past(code)} + 1'b1));

    assert_count_down_R4: assert property (@(posedge clk) disable iff (rst)
        (fall_evt && !cs_n_s && !dir_s && code != MIN_CODE)
        |=> ({1'b0, code} + 1'b1 == {1'b0, $past(code)}));

    assert_hold_deselected_R5: assert property (@(posedge clk) disable iff (rst)
        (fall_evt && cs_n_s) |=> $stable(code));

    assert_top_saturate_R6: assert property (@(posedge clk) disable iff (rst)
        (code == MAX_CODE && dir_s) |=> code == MAX_CODE);

    assert_bottom_saturate_R7: assert property (@(posedge clk) disable iff (rst)
        (code == MIN_CODE && !dir_s) |=> code == MIN_CODE);

    assert_tap_matches_code_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot(tap) && tap[code]);

    assert_single_event_R10: assert property (@(posedge clk) disable iff (rst)
        fall_evt |=> !fall_evt);

endmodule

bind wiper_ctrl wiper_ctrl_checker #(.CODE_W(CODE_W)) u_wiper_chk (
    .clk      (clk),
    .rst      (rst),
    .code     (wiper_code),
    .tap      (tap_sel),
    .fall_evt (fall_evt),
    .cs_n_s   (cs_n_s),
    .dir_s    (dir_s)
);

// File: tb/test_wiper_ctrl.sv
`timescale 1ns/1ps
module test_wiper_ctrl;

    localparam int CODE_W = 7;
    localparam int TAPS   = 1 << CODE_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              strobe_in = 1'b1;
    logic              sel_n_in = 1'b1;
    logic              dir_in = 1'b1;
    logic [CODE_W-1:0] wiper_code;
    logic [TAPS-1:0]   tap_sel;

    int vectors = 0;
    int fails   = 0;
    int cycles  = 0;
    bit done    = 0;

    always #2.5 clk = ~clk;

    wiper_ctrl #(.CODE_W(CODE_W)) i_wiper_ctrl (
        .clk        (clk),
        .rst        (rst),
        .strobe_in  (strobe_in),
        .sel_n_in   (sel_n_in),
        .dir_in     (dir_in),
        .wiper_code (wiper_code),
        .tap_sel    (tap_sel)
    );

    // Behavioural reference: input samples pass through a delay queue
    int  m_code = 64;
    bit  m_hist_str[$];
    bit  m_hist_sel[$];
    bit  m_hist_dir[$];
    bit  m_prev_str = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_code = 64;
            m_hist_str = '{0, 0};
            m_hist_sel = '{0, 0};
            m_hist_dir = '{0, 0};
            m_prev_str = 0;
        end else begin
            bit s, c, d;
            s = m_hist_str[0];
            c = m_hist_sel[0];
            d = m_hist_dir[0];
            if (m_prev_str && !s && !c) begin
                if (d && m_code < 127) m_code++;
                else if (!d && m_code > 0) m_code--;
            end
            m_prev_str = s;
            void'(m_hist_str.pop_front());
            void'(m_hist_sel.pop_front());
            void'(m_hist_dir.pop_front());
            m_hist_str.push_back(strobe_in);
            m_hist_sel.push_back(sel_n_in);
            m_hist_dir.push_back(dir_in);
        end
    end

    // Every-clock comparison (R8 covers the tap relation)
    always @(negedge clk) begin
        if (!rst && !done) begin
            vectors++;
            if (int'(wiper_code) != m_code || tap_sel != (TAPS'(1) << m_code)) begin
                fails++;
                $display("FAIL R8 model compare: code=%0d tap_ok=%0b expected code=%0d",
                         wiper_code, tap_sel == (TAPS'(1) << wiper_code), m_code);
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse(input bit up, input bit sel_n);
        @(negedge clk);
        strobe_in = 1'b1; dir_in = up; sel_n_in = sel_n;
        repeat (3) @(negedge clk);
        strobe_in = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000 && !done) begin
                fails++;
                $display("FAIL watchdog: actual=%0d cycles expected=<100000", cycles);
                finish_run();
            end
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset code", wiper_code, 64);
        chk("R1 reset tap", int'(tap_sel[64]), 1);
        chk("R8 tap onehot", $countones(tap_sel), 1);

        for (int i = 0; i < 3; i++) pulse(1, 0);
        chk("R3 up three", wiper_code, 67);
        for (int i = 0; i < 5; i++) pulse(0, 0);
        chk("R4 down five", wiper_code, 62);
        for (int i = 0; i < 4; i++) pulse(1, 1);
        chk("R5 deselected up", wiper_code, 62);
        for (int i = 0; i < 4; i++) pulse(0, 1);
        chk("R5 deselected down", wiper_code, 62);

        // R9: latency and sampling of direction at the fall
        @(negedge clk); strobe_in = 1'b1; dir_in = 1'b1; sel_n_in = 1'b0;
        repeat (3) @(negedge clk);
        strobe_in = 1'b0;
        @(negedge clk); dir_in = 1'b0;
        chk("R9 after 1 edge", wiper_code, 62);
        @(negedge clk);
        chk("R9 after 2 edges", wiper_code, 62);
        @(negedge clk);
        chk("R9 after 3 edges, dir at fall", wiper_code, 63);

        // R10 / R2: long low gives one step, rising edge gives none
        repeat (40) @(negedge clk);
        chk("R10 long low single step", wiper_code, 63);
        strobe_in = 1'b1;
        repeat (10) @(negedge clk);
        chk("R2 rising edge no step", wiper_code, 63);

        // bottom saturation
        for (int i = 0; i < 70; i++) pulse(0, 0);
        chk("R7 bottom hold", wiper_code, 0);
        chk("R8 tap at zero", int'(tap_sel[0]), 1);
        // full sweep up
        for (int i = 0; i < 127; i++) pulse(1, 0);
        chk("R3 sweep top", wiper_code, 127);
        for (int i = 0; i < 3; i++) pulse(1, 0);
        chk("R6 top hold", wiper_code, 127);
        chk("R8 tap at top", int'(tap_sel[127]), 1);
        // full sweep down
        for (int i = 0; i < 127; i++) pulse(0, 0);
        chk("R4 sweep bottom", wiper_code, 0);
        pulse(0, 0);
        chk("R7 bottom hold again", wiper_code, 0);

        // mid-run reset
        for (int i = 0; i < 9; i++) pulse(1, 0);
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk); rst = 1'b0;
        @(negedge clk);
        chk("R1 reset after activity", wiper_code, 64);

        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule